// File: doc/BRIEF.md
# Memory Access Coalescing Unit

This block sits between a group of sixteen load lanes and a memory controller whose bus is 32 bytes wide. A whole group is presented in one cycle: a byte address for each lane, plus a mask that says which lanes are active. The block works out the fewest bus-aligned line fetches that together cover every active address. It then sends those fetches out one at a time on a valid/ready handshake.

Each fetch carries three things: the aligned line address, a mask of the lanes that the line serves, and the byte offset of every lane inside its own line. With these, the return path can steer data back to the right lanes. A single-cycle done strobe closes the group. A new group is taken only once the block is idle again.

The unit handles only 4-byte element loads. It does not touch returning data, and it does not merge writes.

Top module: `coal_unit`

## Requirements
- R1: Every issued line address equals some active lane's byte address with its low 5 bits cleared, so bits [4:0] of `req_line` are always zero while `req_valid` is high.
- R2: Within one group, each distinct 32-byte window touched by an active lane is requested exactly once, and no other request is issued.
- R3: All sixteen lanes of a group are evaluated together. Sixteen consecutive 4-byte elements starting at 0x00001232 give exactly 3 requests (0x1220, 0x1240, 0x1260), and starting at 0x00001240 they give exactly 2.
- R4: Requests leave in ascending order of the lowest-numbered active lane that touches each line.
- R5: `req_mask` bit t is 1 exactly when lane t is active and its address lies in the requested line.
- R6: Slot t of `req_offs` (bits [5t+4:5t]) carries bits [4:0] of lane t's address.
- R7: Inactive lanes produce no request and never appear in a mask. A group with no active lane raises `done` without issuing any request.
- R8: While `req_valid` is high and `req_ready` is low, the request stays valid and `req_line`/`req_mask` hold their values.
- R9: `done` is a one-cycle pulse. It rises in the cycle after the last request is accepted, or in the cycle after acceptance for an empty group, and it is never high together with `req_valid`.
- R10: `in_ready` is high only while no group is in progress. A group offered while busy is ignored and does not change the requests of the current group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new group is offered |
| in_ready | output | 1 | Block idle; the group is taken on valid and ready |
| in_active | input | 16 | Lane active mask |
| in_addr | input | 512 | Lane byte addresses, lane t at bits [32t+31:32t] |
| req_valid | output | 1 | A line request is presented |
| req_ready | input | 1 | Memory controller takes the request |
| req_line | output | 32 | 32-byte aligned line address |
| req_mask | output | 16 | Lanes served by this line |
| req_offs | output | 80 | Per-lane byte offset inside the line, lane t at bits [5t+4:5t] |
| done | output | 1 | One-cycle end-of-group strobe |

## Verification
The block is driven with several kinds of group:
- Unit-stride runs, aligned and misaligned. These pin down the request counts of R3 and show whether window merging is right.
- All lanes on one address. This isolates whether merging reduces a group to a single fetch.
- Descending and scattered addresses. Here first-touch order differs from address order, so the ordering rule of R4 shows up.
- Random active masks, including the empty and single-lane cases. These separate inactive-lane filtering from merging.

Random stalls on `req_ready` exercise request hold. A second group is also pushed in while the block is busy, to show that it is ignored.

// File: rtl/coal_pkg.sv
package coal_pkg;
    localparam int DEF_THREADS    = 16;
    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_LINE_BYTES = 32;

    typedef enum logic {
        CS_IDLE = 1'b0,
        CS_BUSY = 1'b1
    } coal_state_e;

    function automatic int unsigned off_width(input int unsigned line_bytes);
        return $clog2(line_bytes);
    endfunction
endpackage

// File: rtl/coal_group_store.sv
module coal_group_store #(
    parameter int NT = coal_pkg::DEF_THREADS,
    parameter int AW = coal_pkg::DEF_ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NT*AW-1:0] load_addr,
    input  logic [NT-1:0]    load_act,
    input  logic             retire,
    input  logic [NT-1:0]    retire_mask,
    output logic [NT*AW-1:0] addr_q,
    output logic [NT-1:0]    pending_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            pending_q <= '0;
        end else if (load) begin
            addr_q    <= load_addr;
            pending_q <= load_act;
        end else if (retire) begin
            pending_q <= pending_q & ~retire_mask;
        end
    end
endmodule

// File: rtl/coal_line_pick.sv
module coal_line_pick #(
    parameter int NT = coal_pkg::DEF_THREADS,
    parameter int AW = coal_pkg::DEF_ADDR_W,
    parameter int OW = 5
) (
    input  logic [NT*AW-1:0] addr_i,
    input  logic [NT-1:0]    pending_i,
    output logic             any_o,
    output logic [AW-1:0]    line_o,
    output logic [NT-1:0]    mask_o,
    output logic [NT*OW-1:0] offs_o
);
    localparam int IW = (NT > 1) ? $clog2(NT) : 1;
    localparam logic [AW-1:0] OFF_MASK = AW'((64'd1 << OW) - 64'd1);

    logic [IW-1:0] lead;
    logic [AW-1:0] lead_addr;

    // lowest-numbered pending lane leads the next request
    always_comb begin
        lead = '0;
        for (int i = NT - 1; i >= 0; i--) begin
            if (pending_i[i]) lead = IW'(i);
        end
    end

    assign lead_addr = addr_i[lead*AW +: AW];
    assign any_o     = |pending_i;
    assign line_o    = lead_addr & ~OFF_MASK;

    for (genvar t = 0; t < NT; t++) begin : g_lane
        logic [AW-1:0] a;
        assign a = addr_i[t*AW +: AW];
        assign mask_o[t] = pending_i[t] && (((a ^ lead_addr) & ~OFF_MASK) == '0);
        assign offs_o[t*OW +: OW] = a[OW-1:0];
    end
endmodule

// File: rtl/coal_seq.sv
module coal_seq (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic any_pending,
    input  logic req_ready,
    output logic in_ready,
    output logic load,
    output logic req_valid,
    output logic retire,
    output logic done
);
    import coal_pkg::*;

    coal_state_e state_q, state_d;

    assign in_ready  = (state_q == CS_IDLE);
    assign load      = in_valid && in_ready;
    assign req_valid = (state_q == CS_BUSY) && any_pending;
    assign retire    = req_valid && req_ready;
    assign done      = (state_q == CS_BUSY) && !any_pending;

    always_comb begin
        state_d = state_q;
        case (state_q)
            CS_IDLE: if (load) state_d = CS_BUSY;
            CS_BUSY: if (!any_pending) state_d = CS_IDLE;
            default: state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CS_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/coal_unit.sv
module coal_unit #(
    parameter int NT         = coal_pkg::DEF_THREADS,
    parameter int AW         = coal_pkg::DEF_ADDR_W,
    parameter int LINE_BYTES = coal_pkg::DEF_LINE_BYTES,
    localparam int OW        = coal_pkg::off_width(LINE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [NT-1:0]    in_active,
    input  logic [NT*AW-1:0] in_addr,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [AW-1:0]    req_line,
    output logic [NT-1:0]    req_mask,
    output logic [NT*OW-1:0] req_offs,
    output logic             done
);
    logic             load, retire, any_pending;
    logic [NT*AW-1:0] addr_q;
    logic [NT-1:0]    pending_q;

    coal_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .any_pending (any_pending),
        .req_ready   (req_ready),
        .in_ready    (in_ready),
        .load        (load),
        .req_valid   (req_valid),
        .retire      (retire),
        .done        (done)
    );

    coal_group_store #(.NT(NT), .AW(AW)) u_store (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .load_addr   (in_addr),
        .load_act    (in_active),
        .retire      (retire),
        .retire_mask (req_mask),
        .addr_q      (addr_q),
        .pending_q   (pending_q)
    );

    coal_line_pick #(.NT(NT), .AW(AW), .OW(OW)) u_pick (
        .addr_i    (addr_q),
        .pending_i (pending_q),
        .any_o     (any_pending),
        .line_o    (req_line),
        .mask_o    (req_mask),
        .offs_o    (req_offs)
    );
endmodule

// File: rtl/coal_unit_chk.sv
module coal_unit_chk #(
    parameter int NT = 16,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_line,
    input logic [NT-1:0] req_mask,
    input logic          done
);
    assert_line_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_line[4:0] == 5'd0));

    assert_mask_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_mask != '0));

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_line) && $stable(req_mask)));

    assert_done_alone_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid || done) |-> !in_ready);

    assert_accept_starts_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);
endmodule

bind coal_unit coal_unit_chk #(.NT(NT), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_line  (req_line),
    .req_mask  (req_mask),
    .done      (done)
);

// File: tb/coal_unit_test.sv
module coal_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 16;
    localparam int AW = 32;
    localparam int OW = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [NT-1:0]    in_active = '0;
    logic [NT*AW-1:0] in_addr = '0;
    logic             req_valid;
    logic             req_ready = 1'b0;
    logic [AW-1:0]    req_line;
    logic [NT-1:0]    req_mask;
    logic [NT*OW-1:0] req_offs;
    logic             done;

    int n_checks = 0;
    int n_fail   = 0;

    logic [AW-1:0] lane_addr [NT];
    logic [NT-1:0] lane_act;
    logic [AW-1:0] exp_line [NT];
    logic [NT-1:0] exp_mask [NT];
    int            exp_n;

    coal_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_active(in_active), .in_addr(in_addr), .req_valid(req_valid),
        .req_ready(req_ready), .req_line(req_line), .req_mask(req_mask),
        .req_offs(req_offs), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected requests in first-touch order
    task automatic compute_expected();
        exp_n = 0;
        for (int i = 0; i < NT; i++) begin
            if (lane_act[i]) begin
                logic [AW-1:0] l;
                bit found;
                l = lane_addr[i] & ~32'h1F;
                found = 0;
                for (int j = 0; j < exp_n; j++) begin
                    if (!found && exp_line[j] == l) begin
                        exp_mask[j][i] = 1'b1;
                        found = 1;
                    end
                end
                if (!found) begin
                    exp_line[exp_n] = l;
                    exp_mask[exp_n] = '0;
                    exp_mask[exp_n][i] = 1'b1;
                    exp_n++;
                end
            end
        end
    endtask

    task automatic run_group(input bit intrude);
        int got;
        int cyc;
        bit stalled;
        logic [AW-1:0] s_line;
        logic [NT-1:0] s_mask;
        compute_expected();
        @(negedge clk);
        check(in_ready == 1'b1, "R10 idle before group", 64'(in_ready), 64'd1);
        in_valid  = 1'b1;
        in_active = lane_act;
        for (int i = 0; i < NT; i++) in_addr[i*AW +: AW] = lane_addr[i];
        @(negedge clk);
        if (intrude) begin
            in_active = ~lane_act;
            for (int i = 0; i < NT; i++) in_addr[i*AW +: AW] = 32'hDEAD0000 + 32'(i * 96);
        end else begin
            in_valid = 1'b0;
        end
        got = 0; cyc = 0; stalled = 0;
        forever begin
            req_ready = ($urandom % 4) != 0;
            #1;
            if (stalled) begin
                check(req_valid && req_line == s_line && req_mask == s_mask,
                      "R8 hold on stall", {16'(req_mask), 32'(req_line)}, {16'(s_mask), 32'(s_line)});
            end
            stalled = 0;
            if (done) begin
                check(!req_valid, "R9 done without request", 64'(req_valid), 64'd0);
                break;
            end
            if (req_valid && !req_ready) begin
                stalled = 1; s_line = req_line; s_mask = req_mask;
            end
            if (req_valid && req_ready) begin
                if (got < exp_n) begin
                    check(req_line == exp_line[got], "R1 R4 line address", 64'(req_line), 64'(exp_line[got]));
                    check(req_mask == exp_mask[got], "R5 R7 lane mask", 64'(req_mask), 64'(exp_mask[got]));
                    for (int i = 0; i < NT; i++) begin
                        if (req_offs[i*OW +: OW] != lane_addr[i][4:0])
                            check(0, "R6 lane offset", 64'(req_offs[i*OW +: OW]), 64'(lane_addr[i][4:0]));
                    end
                    check(1, "R6 offsets", 0, 0);
                end else begin
                    check(0, "R2 extra request", 64'(got + 1), 64'(exp_n));
                end
                got++;
            end
            cyc++;
            if (cyc > 200) begin
                check(0, "R9 done never raised", 64'(cyc), 64'd0);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(got == exp_n, "R2 request count", 64'(got), 64'(exp_n));
        @(negedge clk);
        #1;
        check(in_ready && !done && !req_valid, "R9 R10 back to idle",
              {62'd0, in_ready, done}, 64'd2);
        req_ready = 1'b0;
    endtask

    task automatic set_stride(input logic [AW-1:0] base, input int step);
        for (int i = 0; i < NT; i++) lane_addr[i] = base + 32'(i * step);
    endtask

    initial begin
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(in_ready == 1'b1 && req_valid == 1'b0 && done == 1'b0, "reset state",
              {61'd0, in_ready, req_valid, done}, 64'd4);

        // R3 misaligned unit-stride run
        set_stride(32'h00001232, 4); lane_act = '1;
        compute_expected();
        check(exp_n == 3, "R3 model count misaligned", 64'(exp_n), 64'd3);
        run_group(0);
        // R3 aligned run
        set_stride(32'h00001240, 4); lane_act = '1;
        compute_expected();
        check(exp_n == 2, "R3 model count aligned", 64'(exp_n), 64'd2);
        run_group(0);
        // all lanes on one address
        set_stride(32'h0000ABCC, 0); lane_act = '1;
        run_group(0);
        // R7 empty group
        set_stride(32'h00002000, 4); lane_act = '0;
        run_group(0);
        // R4 descending addresses
        set_stride(32'h00004000, -20); lane_act = '1;
        run_group(0);
        // single lane 15, R7
        set_stride(32'h00008000, 64); lane_act = 16'h8000;
        run_group(0);
        // R10 intrusion while busy
        set_stride(32'h00003010, 12); lane_act = 16'hF0F3;
        run_group(1);

        for (int g = 0; g < 150; g++) begin
            int kind;
            kind = $urandom % 4;
            for (int i = 0; i < NT; i++) begin
                case (kind)
                    0: lane_addr[i] = 32'h00010000 + 32'(i * 4) + 32'(($urandom % 8) * 4);
                    1: lane_addr[i] = 32'h00020000 + 32'(($urandom % 6) * 32) + 32'($urandom % 32);
                    2: lane_addr[i] = $urandom;
                    default: lane_addr[i] = 32'h00030000 + 32'(($urandom % 64) * 4);
                endcase
            end
            lane_act = 16'($urandom);
            if (g % 10 == 0) lane_act = '1;
            run_group(g % 17 == 5);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule